// File: doc/BRIEF.md
# DMA Stream Enable and Item Counter

This block governs a single DMA stream: when it may run, how many data items remain, and what happens when the count runs out. Software reaches three word registers through a simple write port and a combinational read port. The control register holds the run bit and the circular-mode bit. The count register holds a 16-bit item count. The event register holds sticky flags, and software clears them by writing a 1 to each flag it wants to clear. The datapath pulses `item_done` each time it moves one item. The block counts the item down and tells the datapath through `req_ok` whether the stream may ask for another transfer.

The run bit also serves as the stream's ready indication, and hardware can drop it. It falls when a transfer ends in normal mode, on a bus error, and on a bad FIFO-threshold/burst pairing. While the stream runs, software cannot change its configuration or its count. The only control-register write that takes effect is clearing the run bit. A shadow register keeps the count software last wrote. In circular mode the shadow refills the counter at zero, and it refills the counter again each time software restarts the stream.

The register addresses follow the stream index `STREAM_ID` with a stride of 0x18. The event register is at 0x08, the control register at 0x10 and the count register at 0x14, each plus 0x18 × `STREAM_ID`.

Top module: `dma_stream_ctrl`

## Requirements
- R1: After reset `stream_on`, `req_ok` and `tc_pulse` are 0, and the control, count and event registers all read 0.
- R2: A write to the count register (offset 0x14) loads bits 15:0 into both the live count and the shadow only while the stream is off. While it is on, the write is ignored. Bits 31:16 always read 0.
- R3: While the stream is on and the count is nonzero, `req_ok` is 1 and each `item_done` pulse lowers the count by one.
- R4: In normal mode (control bit 1 = 0), the item that takes the count from 1 to 0 does three things in the next cycle: it clears `stream_on`, it leaves the count at 0, and it raises `tc_pulse` for exactly one cycle. It also sets event bit 0. Later `item_done` pulses leave the count at 0.
- R5: In circular mode (control bit 1 = 1), the item that takes the count from 1 to 0 refills the count from the shadow. The stream stays on, `tc_pulse` rises for one cycle and event bit 0 is set.
- R6: Writing control bit 0 = 1 while the stream is off turns it on and refills the live count from the shadow, even after a partial run.
- R7: With the stream on and the count at 0, `req_ok` is 0, `item_done` has no effect and the stream stays on.
- R8: While the stream is on, a `bus_err` pulse clears `stream_on` and sets event bit 1, and a `fifo_err` pulse clears `stream_on` and sets event bit 2. The count is left unchanged in both cases.
- R9: While the stream is on, a control write with bit 0 = 0 turns it off. Any other control-bit change written while it is on (the circular bit) is ignored.
- R10: A control write with bit 0 = 1 is ignored while any event bit is set. Writing 1s to the event register (offset 0x08) clears those bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| item_done | input | 1 | One data item moved by the datapath |
| bus_err | input | 1 | Bus transfer error pulse |
| fifo_err | input | 1 | FIFO threshold incompatible with burst size |
| stream_on | output | 1 | Stream enabled / not ready for reconfiguration |
| req_ok | output | 1 | Stream may issue a transfer request |
| tc_pulse | output | 1 | One-cycle transfer-complete pulse |

## Verification
The checker assumes the datapath raises `item_done` only while `req_ok` is high. Pulses at other times are harmless, and R7 exercises them on purpose. It also assumes the error inputs are single-cycle pulses. The counter-lock property covers only write cycles with no accepted item, because an item that completes in the same cycle changes the count legitimately. The bench drives every input on the falling edge and applies one stimulus at a time, with two exceptions. The write-while-on case and the zero-count case each combine a write or pulse with a held state, because those combinations are what the checks target.

// File: rtl/dma_stream_pkg.sv
package dma_stream_pkg;
  localparam int FLG_TC   = 0;
  localparam int FLG_BUS  = 1;
  localparam int FLG_FIFO = 2;
  localparam int FLG_W    = 3;

  localparam int STRIDE   = 'h18;
  localparam int OFS_FLG  = 'h08;
  localparam int OFS_CTRL = 'h10;
  localparam int OFS_CNT  = 'h14;

  function automatic int reg_addr_of(input int id, input int ofs);
    return ofs + STRIDE * id;
  endfunction
endpackage

// File: rtl/dma_stream_regif.sv
module dma_stream_regif
  import dma_stream_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int CNT_W     = 16,
  parameter int STREAM_ID = 0
) (
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic             en,
  input  logic             circ,
  input  logic [CNT_W-1:0] cnt,
  input  logic [FLG_W-1:0] flags,
  output logic             wr_ctrl,
  output logic             wr_cnt,
  output logic             wr_flg,
  output logic [DW-1:0]    reg_rdata
);
  localparam logic [AW-1:0] A_FLG  = AW'(reg_addr_of(STREAM_ID, OFS_FLG));
  localparam logic [AW-1:0] A_CTRL = AW'(reg_addr_of(STREAM_ID, OFS_CTRL));
  localparam logic [AW-1:0] A_CNT  = AW'(reg_addr_of(STREAM_ID, OFS_CNT));

  logic hit_flg, hit_ctrl, hit_cnt;

  assign hit_flg  = (reg_addr == A_FLG);
  assign hit_ctrl = (reg_addr == A_CTRL);
  assign hit_cnt  = (reg_addr == A_CNT);

  assign wr_ctrl = reg_wr && hit_ctrl;
  assign wr_cnt  = reg_wr && hit_cnt;
  assign wr_flg  = reg_wr && hit_flg;

  always_comb begin
    reg_rdata = '0;
    if (hit_ctrl) begin
      reg_rdata[0] = en;
      reg_rdata[1] = circ;
    end else if (hit_cnt) begin
      reg_rdata[CNT_W-1:0] = cnt;
    end else if (hit_flg) begin
      reg_rdata[FLG_W-1:0] = flags;
    end
  end
endmodule

// File: rtl/dma_stream_counter.sv
module dma_stream_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             circ,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wdata,
  input  logic             reload,
  input  logic             item_done,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] shadow,
  output logic             last_item,
  output logic             tc_pulse
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, sh_q;
  logic             sw_load, done_acc, cnt_upd, tc_q;

  assign sw_load   = wr_cnt && !en;
  assign done_acc  = item_done && en && (cnt_q != '0);
  assign last_item = done_acc && (cnt_q == ONE);
  assign cnt_upd   = sw_load || reload || done_acc;

  always_comb begin
    cnt_d = cnt_q;
    if (sw_load)
      cnt_d = wdata;
    else if (reload)
      cnt_d = sh_q;
    else if (done_acc)
      cnt_d = (last_item && circ) ? sh_q : cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
      tc_q  <= 1'b0;
    end else begin
      if (cnt_upd) cnt_q <= cnt_d;
      if (sw_load) sh_q  <= wdata;
      tc_q <= last_item;
    end
  end

  assign cnt      = cnt_q;
  assign shadow   = sh_q;
  assign tc_pulse = tc_q;
endmodule

// File: rtl/dma_stream_enable.sv
module dma_stream_enable
  import dma_stream_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic [1:0]       ctrl_wdata,
  input  logic             wr_flg,
  input  logic [FLG_W-1:0] flg_wdata,
  input  logic             last_item,
  input  logic             bus_err,
  input  logic             fifo_err,
  output logic             en,
  output logic             circ,
  output logic [FLG_W-1:0] flags,
  output logic             reload
);
  logic             en_q, en_d, circ_q, circ_d, set_go, hw_stop, sw_stop, flg_upd;
  logic [FLG_W-1:0] flg_q, flg_d, flg_set, flg_clr;

  assign set_go  = wr_ctrl && !en_q && ctrl_wdata[0] && (flg_q == '0);
  assign sw_stop = wr_ctrl && !ctrl_wdata[0];
  assign hw_stop = (last_item && !circ_q) || bus_err || fifo_err;

  always_comb begin
    flg_set           = '0;
    flg_set[FLG_TC]   = last_item;
    flg_set[FLG_BUS]  = bus_err && en_q;
    flg_set[FLG_FIFO] = fifo_err && en_q;
    flg_clr           = wr_flg ? flg_wdata : '0;
    flg_d             = (flg_q & ~flg_clr) | flg_set;
    flg_upd           = wr_flg || (flg_set != '0);
  end

  always_comb begin
    if (en_q) en_d = !(sw_stop || hw_stop);
    else      en_d = set_go;
    circ_d = (wr_ctrl && !en_q) ? ctrl_wdata[1] : circ_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      circ_q <= 1'b0;
      flg_q  <= '0;
    end else begin
      en_q   <= en_d;
      circ_q <= circ_d;
      if (flg_upd) flg_q <= flg_d;
    end
  end

  assign en     = en_q;
  assign circ   = circ_q;
  assign flags  = flg_q;
  assign reload = set_go;
endmodule

// File: rtl/dma_stream_ctrl.sv
module dma_stream_ctrl
  import dma_stream_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int CNT_W     = 16,
  parameter int STREAM_ID = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          item_done,
  input  logic          bus_err,
  input  logic          fifo_err,
  output logic          stream_on,
  output logic          req_ok,
  output logic          tc_pulse
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             wr_ctrl_w, wr_cnt_w, wr_flg_w, circ_w, last_w, reload_w;
  logic [CNT_W-1:0] cnt_w, shadow_w;
  logic [FLG_W-1:0] flags_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  dma_stream_regif #(
    .AW(AW), .DW(DW), .CNT_W(CNT_W), .STREAM_ID(STREAM_ID)
  ) u_regif (
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .en        (stream_on),
    .circ      (circ_w),
    .cnt       (cnt_w),
    .flags     (flags_w),
    .wr_ctrl   (wr_ctrl_w),
    .wr_cnt    (wr_cnt_w),
    .wr_flg    (wr_flg_w),
    .reg_rdata (reg_rdata)
  );

  dma_stream_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (stream_on),
    .circ      (circ_w),
    .wr_cnt    (wr_cnt_w),
    .wdata     (reg_wdata[CNT_W-1:0]),
    .reload    (reload_w),
    .item_done (item_done),
    .cnt       (cnt_w),
    .shadow    (shadow_w),
    .last_item (last_w),
    .tc_pulse  (tc_pulse)
  );

  dma_stream_enable u_enable (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_ctrl    (wr_ctrl_w),
    .ctrl_wdata (reg_wdata[1:0]),
    .wr_flg     (wr_flg_w),
    .flg_wdata  (reg_wdata[FLG_W-1:0]),
    .last_item  (last_w),
    .bus_err    (bus_err),
    .fifo_err   (fifo_err),
    .en         (stream_on),
    .circ       (circ_w),
    .flags      (flags_w),
    .reload     (reload_w)
  );

  assign req_ok = stream_on && (cnt_w != '0);
endmodule

// File: rtl/dma_stream_ctrl_chk.sv
module dma_stream_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             circ,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] shadow,
  input logic             wr_cnt,
  input logic             item_done,
  input logic             bus_err,
  input logic             tc_pulse
);
  // R2
  cnt_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_cnt && !item_done) |=> $stable(cnt));

  // R4
  tc_from_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> ($past(cnt) == CNT_W'(1)));

  // R4
  normal_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pulse && !circ) |-> !en);

  // R5
  circ_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pulse && circ) |-> (cnt == shadow));

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> $stable(shadow));

  // R7
  zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt == '0) |=> (cnt == '0));

  // R8
  err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bus_err) |=> !en);
endmodule

bind dma_stream_ctrl dma_stream_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .en        (stream_on),
  .circ      (circ_w),
  .cnt       (cnt_w),
  .shadow    (shadow_w),
  .wr_cnt    (wr_cnt_w),
  .item_done (item_done),
  .bus_err   (bus_err),
  .tc_pulse  (tc_pulse)
);

// File: tb/dma_stream_ctrl_bench.sv
`timescale 1ns/1ps
module dma_stream_ctrl_bench;
  localparam logic [7:0] A_FLG = 8'h08, A_CTRL = 8'h10, A_CNT = 8'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        item_done = 1'b0, bus_err = 1'b0, fifo_err = 1'b0;
  logic        stream_on, req_ok, tc_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_stream_ctrl u_dma_stream_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .item_done(item_done),
    .bus_err(bus_err), .fifo_err(fifo_err), .stream_on(stream_on),
    .req_ok(req_ok), .tc_pulse(tc_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    item_done = 1'b1;
    @(negedge clk);
    item_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 stream_on", 32'(stream_on), 0);
    check("R1 req_ok", 32'(req_ok), 0);
    check("R1 tc_pulse", 32'(tc_pulse), 0);
    rd(A_CTRL, d); check("R1 ctrl", d, 0);
    rd(A_CNT, d);  check("R1 count", d, 0);
    rd(A_FLG, d);  check("R1 flags", d, 0);
  endtask

  task automatic t_normal();
    logic [31:0] d;
    wr(A_CNT, 32'hFFFF_0003);
    rd(A_CNT, d); check("R2 upper zero", d, 32'h3);
    wr(A_CTRL, 32'h1);
    check("R6 on", 32'(stream_on), 1);
    check("R3 req_ok", 32'(req_ok), 1);
    wr(A_CNT, 32'h9);
    rd(A_CNT, d); check("R2 locked", d, 32'h3);
    pulse_done(); rd(A_CNT, d); check("R3 dec", d, 32'h2);
    pulse_done(); rd(A_CNT, d); check("R3 dec", d, 32'h1);
    @(negedge clk); item_done = 1'b1;
    @(negedge clk); item_done = 1'b0;
    check("R4 tc", 32'(tc_pulse), 1);
    check("R4 off", 32'(stream_on), 0);
    rd(A_CNT, d); check("R4 stays zero", d, 0);
    check("R4 tc one cycle", 32'(tc_pulse), 0);
    rd(A_FLG, d); check("R4 tc flag", d, 32'h1);
    pulse_done(); rd(A_CNT, d); check("R4 zero hold", d, 0);
  endtask

  task automatic t_flag_block();
    logic [31:0] d;
    wr(A_CTRL, 32'h1);
    check("R10 blocked", 32'(stream_on), 0);
    wr(A_FLG, 32'h7);
    rd(A_FLG, d); check("R10 w1c", d, 0);
    wr(A_CTRL, 32'h1);
    check("R10 enable", 32'(stream_on), 1);
    rd(A_CNT, d); check("R6 reload", d, 32'h3);
    pulse_done();
    wr(A_CTRL, 32'h0);
    check("R9 sw stop", 32'(stream_on), 0);
    rd(A_CNT, d); check("R9 count kept", d, 32'h2);
    wr(A_CTRL, 32'h1);
    rd(A_CNT, d); check("R6 reload partial", d, 32'h3);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_circ();
    logic [31:0] d;
    wr(A_CNT, 32'h2);
    wr(A_CTRL, 32'h2);
    wr(A_CTRL, 32'h3);
    pulse_done();
    @(negedge clk); item_done = 1'b1;
    @(negedge clk); item_done = 1'b0;
    check("R5 tc", 32'(tc_pulse), 1);
    check("R5 on", 32'(stream_on), 1);
    rd(A_CNT, d); check("R5 refill", d, 32'h2);
    rd(A_FLG, d); check("R5 tc flag", d, 32'h1);
    wr(A_CTRL, 32'h1);
    rd(A_CTRL, d); check("R9 circ locked", d, 32'h3);
    pulse_done(); pulse_done();
    check("R5 still on", 32'(stream_on), 1);
    rd(A_CNT, d); check("R5 refill again", d, 32'h2);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, d); check("R9 off circ kept", d, 32'h2);
    wr(A_FLG, 32'h1);
  endtask

  task automatic t_err();
    logic [31:0] d;
    wr(A_CTRL, 32'h1);
    check("R8 on", 32'(stream_on), 1);
    @(negedge clk); bus_err = 1'b1;
    @(negedge clk); bus_err = 1'b0;
    check("R8 bus off", 32'(stream_on), 0);
    rd(A_FLG, d); check("R8 bus flag", d, 32'h2);
    rd(A_CNT, d); check("R8 count kept", d, 32'h2);
    wr(A_FLG, 32'h2);
    wr(A_CTRL, 32'h1);
    @(negedge clk); fifo_err = 1'b1;
    @(negedge clk); fifo_err = 1'b0;
    check("R8 fifo off", 32'(stream_on), 0);
    rd(A_FLG, d); check("R8 fifo flag", d, 32'h4);
    wr(A_FLG, 32'h4);
  endtask

  task automatic t_zero();
    logic [31:0] d;
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'h0);
    wr(A_CTRL, 32'h1);
    check("R7 on", 32'(stream_on), 1);
    check("R7 no req", 32'(req_ok), 0);
    pulse_done();
    rd(A_CNT, d); check("R7 count", d, 0);
    check("R7 still on", 32'(stream_on), 1);
    check("R7 no tc", 32'(tc_pulse), 0);
    wr(A_CTRL, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_normal();
    t_flag_block();
    t_circ();
    t_err();
    t_zero();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule